// File: doc/BRIEF.md
# Power-Down Sequencer with Alarm Wake

This block decides when a processor core may run. It has three working states, RUNNING, STANDBY and POWERDOWN, plus a WAKING state between power-down and running. Software issues a single register write that carries a request code and a wake delay. In STANDBY the core clock keeps toggling and the core sits idle until an interrupt arrives. In POWERDOWN the core clock enable and the oscillator enable both drop. A slow alarm counter keeps decrementing, driven by the always-on low-frequency clock.

When the alarm expires, the oscillator enable returns and the block enters WAKING. It then counts a fixed number of slow-clock edges so the oscillator can settle. After that it raises the clock enable again, and the core continues from the state it held when it stopped. The block itself runs on the free-running reference clock. The slow clock arrives as a plain input and is resynchronised into a one-cycle tick.

Named transitions:
- RUN_TO_STBY: a standby write.
- RUN_TO_PDOWN: a power-down write with no interrupt pending.
- STBY_TO_RUN: an interrupt.
- PDOWN_TO_WAKE: alarm expiry.
- WAKE_TO_RUN: the settle count is complete.

Top module: `power_down_ctrl`

## Requirements
- R1: After reset the block is in RUNNING: `state_rd`=0, `clk_en`=1, `osc_en`=1, `cpu_idle`=0.
- R2: In RUNNING, a write with request code 1 in `wr_data[1:0]` moves the block to STANDBY on the next clock: `state_rd`=1, `clk_en`=1, `osc_en`=1, `cpu_idle`=1.
- R3: In STANDBY, `irq` high returns the block to RUNNING on the next clock.
- R4: In RUNNING, a write with request code 2 and `irq` low moves the block to POWERDOWN: `state_rd`=2, `clk_en`=0, `osc_en`=0, `cpu_idle`=1. The wake delay D is taken from `wr_data[DELAY_W+1:2]`.
- R5: POWERDOWN moves to WAKING on the max(D,1)-th rising edge of `slow_clk` after entry, and not before. A delay of 0 therefore wakes on the first edge.
- R6: WAKING shows `state_rd`=3, `osc_en`=1, `clk_en`=0 and `cpu_idle`=1. The block returns to RUNNING with `clk_en`=1 on exactly the 64th `slow_clk` rising edge after entering WAKING.
- R7: A power-down write while `irq` is high is ignored, and the block stays in RUNNING.
- R8: `irq` has no effect in POWERDOWN or WAKING. Register writes have no effect in any state other than RUNNING.
- R9: Request codes 0 and 3 have no effect in RUNNING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Always-on low-frequency clock, sampled as data |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DELAY_W+2 | [1:0] request code, [DELAY_W+1:2] wake delay |
| irq | input | 1 | Interrupt or reschedule request |
| clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_idle | output | 1 | Core is not executing |
| state_rd | output | 2 | State readback: 0 run, 1 standby, 2 power-down, 3 waking |

## Verification
The wake alarm is driven with delays of 0, 1, 2, 5 and 9. Checking the state one slow edge before and at the expected expiry tells an off-by-one counter apart from a correct one. The 0 and 1 cases separate "zero wakes at once" from "zero never wakes". The settle phase is probed at edge 63 and edge 64, which exposes a short or long settle count. Directed patterns then cover the standby entry and exit, the power-down write blocked by an interrupt, and interrupts and writes sent in states that must ignore them. These confirm that each transition fires only on its own trigger.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_STBY  = 2'd1,
        PS_PDOWN = 2'd2,
        PS_WAKE  = 2'd3
    } pstate_t;

    localparam logic [1:0] REQ_NONE  = 2'd0;
    localparam logic [1:0] REQ_STBY  = 2'd1;
    localparam logic [1:0] REQ_PDOWN = 2'd2;
    localparam logic [1:0] REQ_RSVD  = 2'd3;

endpackage

// File: rtl/pdc_tick_sync.sv
module pdc_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk,
    output logic tick
);
    // STAGES synchroniser flops followed by one history flop for edge detection
    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SW-2:0], slow_clk};
    end

    assign tick = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/pdc_alarm.sv
module pdc_alarm #(
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DELAY_W-1:0] load_val,
    input  logic               run,
    input  logic               tick,
    output logic               expire
);
    localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

    logic [DELAY_W-1:0] cnt;
    logic               last;

    // remaining count of 0 or 1 means this tick is the final one
    assign last   = (cnt <= ONE);
    assign expire = run & tick & last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (run && tick && !last) cnt <= cnt - ONE;
    end

endmodule

// File: rtl/pdc_settle.sv
module pdc_settle #(
    parameter int SETTLE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt;

    assign done = run & tick & (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else if (tick) cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
    import pdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] req,
    input  logic       irq,
    input  logic       alarm_exp,
    input  logic       settle_done,
    output logic       pd_accept,
    output logic       in_pdown,
    output logic       in_wake,
    output logic       clk_en,
    output logic       osc_en,
    output logic       cpu_idle,
    output logic [1:0] state_rd
);
    pstate_t state, nxt;

    // a power-down write is taken only in RUN with no interrupt pending
    assign pd_accept = (state == PS_RUN) && wr_en && (req == REQ_PDOWN) && !irq;

    always_comb begin
        nxt = state;
        unique case (state)
            PS_RUN: begin
                if (wr_en && req == REQ_STBY) nxt = PS_STBY;   // RUN_TO_STBY
                else if (pd_accept)           nxt = PS_PDOWN;  // RUN_TO_PDOWN
            end
            PS_STBY:  if (irq)         nxt = PS_RUN;           // STBY_TO_RUN
            PS_PDOWN: if (alarm_exp)   nxt = PS_WAKE;          // PDOWN_TO_WAKE
            PS_WAKE:  if (settle_done) nxt = PS_RUN;           // WAKE_TO_RUN
            default:                   nxt = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_RUN;
        else        state <= nxt;
    end

    always_comb begin
        clk_en   = 1'b0;
        osc_en   = 1'b1;
        cpu_idle = 1'b1;
        in_pdown = 1'b0;
        in_wake  = 1'b0;
        unique case (state)
            PS_RUN: begin
                clk_en   = 1'b1;
                cpu_idle = 1'b0;
            end
            PS_STBY:  clk_en = 1'b1;
            PS_PDOWN: begin
                osc_en   = 1'b0;
                in_pdown = 1'b1;
            end
            PS_WAKE:  in_wake = 1'b1;
            default:  clk_en = 1'b0;
        endcase
        state_rd = state;
    end

endmodule

// File: rtl/power_down_ctrl.sv
module power_down_ctrl #(
    parameter int DELAY_W     = 16,
    parameter int SETTLE      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_clk,
    input  logic               wr_en,
    input  logic [DELAY_W+1:0] wr_data,
    input  logic               irq,
    output logic               clk_en,
    output logic               osc_en,
    output logic               cpu_idle,
    output logic [1:0]         state_rd
);
    logic tick, pd_accept, in_pdown, in_wake, alarm_exp, settle_done;

    pdc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .tick(tick)
    );

    pdc_alarm #(.DELAY_W(DELAY_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .load(pd_accept),
        .load_val(wr_data[DELAY_W+1:2]), .run(in_pdown), .tick(tick),
        .expire(alarm_exp)
    );

    pdc_settle #(.SETTLE(SETTLE)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(in_wake), .tick(tick), .done(settle_done)
    );

    pdc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .req(wr_data[1:0]), .irq(irq),
        .alarm_exp(alarm_exp), .settle_done(settle_done), .pd_accept(pd_accept),
        .in_pdown(in_pdown), .in_wake(in_wake), .clk_en(clk_en), .osc_en(osc_en),
        .cpu_idle(cpu_idle), .state_rd(state_rd)
    );

endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
    parameter int DELAY_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [DELAY_W+1:0] wr_data,
    input logic               irq,
    input logic               clk_en,
    input logic               osc_en,
    input logic [1:0]         state_rd
);
    a_r4_pdown_gated: assert property (@(posedge clk) disable iff (!rst_n)
        state_rd == 2'd2 |-> (!clk_en && !osc_en));

    a_r6_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
        state_rd == 2'd3 |-> (!clk_en && osc_en));

    a_r3_stby_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_rd == 2'd1 && irq) |=> state_rd == 2'd0);

    a_r7_pd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_rd == 2'd0 && wr_en && wr_data[1:0] == 2'd2 && irq) |=> state_rd == 2'd0);

    a_r5_pdown_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state_rd == 2'd2 |=> (state_rd == 2'd2 || state_rd == 2'd3));

    a_r8_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state_rd == 2'd3 |=> (state_rd == 2'd3 || state_rd == 2'd0));

endmodule

bind power_down_ctrl pdc_checker #(.DELAY_W(DELAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .irq(irq),
    .clk_en(clk_en), .osc_en(osc_en), .state_rd(state_rd)
);

// File: tb/sim_power_down_ctrl.sv
`timescale 1ns/1ps
module sim_power_down_ctrl;
    localparam int DW = 16;
    localparam int NV = 5;
    localparam logic [DW-1:0] V_DLY [NV] = '{16'd0, 16'd1, 16'd2, 16'd5, 16'd9};
    localparam int            V_EXP [NV] = '{1, 1, 2, 5, 9};

    logic clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0, wr_en = 1'b0, irq = 1'b0;
    logic [DW+1:0] wr_data = '0;
    logic clk_en, osc_en, cpu_idle;
    logic [1:0] state_rd;
    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    power_down_ctrl #(.DELAY_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en), .wr_data(wr_data),
        .irq(irq), .clk_en(clk_en), .osc_en(osc_en), .cpu_idle(cpu_idle), .state_rd(state_rd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic outs(input string tag, input int st, input int ce, input int oe, input int idl);
        chk({tag, " state"}, state_rd, st);
        chk({tag, " clk_en"}, clk_en, ce);
        chk({tag, " osc_en"}, osc_en, oe);
        chk({tag, " idle"}, cpu_idle, idl);
    endtask

    task automatic wr(input logic [1:0] code, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = {d, code};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_clk = 1'b1;
            repeat (4) @(negedge clk);
            slow_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        outs("R1 reset", 0, 1, 1, 0);

        // vector loop: power-down with delay, wake on expected edge, settle 64 edges
        for (int v = 0; v < NV; v++) begin
            wr(2'd2, V_DLY[v]);
            outs("R4 pdown entry", 2, 0, 0, 1);
            if (V_EXP[v] > 1) slow(V_EXP[v] - 1);
            chk("R5 before expiry", state_rd, 2);
            slow(1);
            outs("R5/R6 waking", 3, 0, 1, 1);
            slow(63);
            chk("R6 settle edge 63", state_rd, 3);
            slow(1);
            outs("R6 back to run", 0, 1, 1, 0);
        end

        // standby entry and exit
        wr(2'd1, 16'd0);
        outs("R2 standby", 1, 1, 1, 1);
        slow(3);
        chk("R2 standby holds", state_rd, 1);
        wr(2'd2, 16'd1);
        chk("R8 write in standby ignored", state_rd, 1);
        @(negedge clk); irq = 1'b1;
        @(negedge clk); irq = 1'b0;
        outs("R3 irq exits standby", 0, 1, 1, 0);

        // power-down blocked by pending interrupt
        @(negedge clk); irq = 1'b1;
        wr(2'd2, 16'd3);
        chk("R7 pdown with irq ignored", state_rd, 0);
        chk("R7 clk_en kept", clk_en, 1);
        @(negedge clk); irq = 1'b0;

        // reserved and no-op codes
        wr(2'd0, 16'd4);
        chk("R9 code 0", state_rd, 0);
        wr(2'd3, 16'd4);
        chk("R9 code 3", state_rd, 0);

        // irq and writes ignored in power-down and waking
        wr(2'd2, 16'd2);
        @(negedge clk); irq = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 irq in pdown", state_rd, 2);
        irq = 1'b0;
        wr(2'd1, 16'd0);
        chk("R8 write in pdown", state_rd, 2);
        slow(2);
        chk("R5 wake after 2", state_rd, 3);
        @(negedge clk); irq = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 irq in waking", state_rd, 3);
        irq = 1'b0;
        wr(2'd2, 16'd7);
        chk("R8 write in waking", state_rd, 3);
        slow(64);
        outs("R6 run after settle", 0, 1, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule